// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides, once per clock cycle, which of sixteen DMA channels gets the next transfer slot. The requests come from eight internal FIFOs. Each FIFO raises two requests: a drain request when it holds data that should be moved out, and a fill request when it has room for more data. The two requests of a FIFO form two separate channels. Each channel has an enable bit and a 4-bit priority level.

A mode input chooses between two policies. In priority mode, the highest-level requester wins. Ties within a level are rotated by a pointer that each level keeps. In round-robin mode, priorities are ignored and the search starts just after the channel granted last. The result is a registered channel index and a valid strobe. A grant covers exactly one slot, and arbitration runs again on every cycle.

Top module: `dmaReqArbiter`

## Requirements
- R1: While reset is asserted and right after its release, `grantValid` is 0, `grantIdx` is 0, and every per-level pointer holds channel 15.
- R2: Channel 2*f is the drain request `wmReq[f]` of FIFO f, and channel 2*f+1 is its fill request `hungryReq[f]`.
- R3: A channel whose bit in `chanEn` is 0 is never granted, whatever its request.
- R4: In a cycle with no enabled request, `grantValid` is 0 after the next edge and `grantIdx` keeps its previous value.
- R5: Requests sampled at a rising edge produce the grant after that same edge. A grant lasts one cycle, and a new decision is made on every edge.
- R6: With `rrMode` = 0, the granted channel has the largest priority value among the enabled requesters. Priority field c is `chanPrio[4c+3:4c]`, and 15 is the highest value.
- R7: With `rrMode` = 0 and several requesters sharing the top level, the search starts at the channel after that level's pointer, in ascending order with wrap. The pointer then records the winner.
- R8: With `rrMode` = 1, priority values are ignored. The search starts at the channel after the current `grantIdx`, in ascending order with wrap.
- R9: A level's pointer changes only on a priority-mode grant at that level. Round-robin grants and grants at other levels leave it unchanged.
- R10: Every grant, in either mode, updates the round-robin starting point (`grantIdx`) to the channel granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wmReq | input | 8 | Drain (watermark) request per FIFO |
| hungryReq | input | 8 | Fill (space available) request per FIFO |
| chanEn | input | 16 | Per-channel enable |
| chanPrio | input | 64 | 4-bit priority per channel, channel c at bits 4c+3..4c |
| rrMode | input | 1 | 1 = round-robin, 0 = priority with in-level rotation |
| grantIdx | output | 4 | Channel granted (holds its value while idle) |
| grantValid | output | 1 | A grant is present this cycle |

## Verification
Every internal pointer shows up at the ports within one cycle of its use. A level pointer that is corrupted or updated in the wrong mode moves the winner of the next tie at that level to the wrong channel. A wrong last-grant register shifts the first round-robin winner. Because outputs are registered once, any error in the masking, in finding the top level or in the rotating search appears in `grantIdx` or `grantValid` on the edge right after the stimulus. Tie rotation is checked across the change of mode, so a leak between the two pointer sets is seen.

// File: rtl/dmaArbPkg.sv
package dmaArbPkg;
  localparam int unsigned DEF_FIFO_CNT = 8;
  localparam int unsigned DEF_PRIO_W   = 4;

  // Strobes from control to datapath for one arbitration slot
  typedef struct packed {
    logic arbLoad;   // at least one enabled request: latch a new winner
    logic idleHold;  // nothing to grant: drop valid, keep index
    logic prioSel;   // search base comes from the level pointer bank
  } arbStrobe_t;
endpackage

// File: rtl/dmaArbCtrl.sv
module dmaArbCtrl
  import dmaArbPkg::*;
#(
  parameter int unsigned NUM_CHAN = 16,
  parameter int unsigned PRIO_W   = DEF_PRIO_W
) (
  input  logic [NUM_CHAN-1:0]        effReq,
  input  logic [NUM_CHAN*PRIO_W-1:0] chanPrio,
  input  logic                       rrMode,
  output arbStrobe_t                 strobe,
  output logic [NUM_CHAN-1:0]        candMask,
  output logic [PRIO_W-1:0]          topLevel
);

  // Highest level present among enabled requesters
  always_comb begin
    topLevel = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (effReq[c] && (chanPrio[c*PRIO_W +: PRIO_W] > topLevel)) begin
        topLevel = chanPrio[c*PRIO_W +: PRIO_W];
      end
    end
  end

  // Candidates: all requesters in round-robin, top-level ones otherwise
  always_comb begin
    for (int c = 0; c < NUM_CHAN; c++) begin
      candMask[c] = effReq[c] &&
                    (rrMode || (chanPrio[c*PRIO_W +: PRIO_W] == topLevel));
    end
  end

  always_comb begin
    strobe.arbLoad  = |effReq;
    strobe.idleHold = ~(|effReq);
    strobe.prioSel  = ~rrMode;
  end

endmodule

// File: rtl/dmaArbDatapath.sv
module dmaArbDatapath
  import dmaArbPkg::*;
#(
  parameter int unsigned NUM_CHAN = 16,
  parameter int unsigned PRIO_W   = DEF_PRIO_W,
  localparam int unsigned CHAN_W  = $clog2(NUM_CHAN),
  localparam int unsigned LEVELS  = 1 << PRIO_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  arbStrobe_t          strobe,
  input  logic [NUM_CHAN-1:0] candMask,
  input  logic [PRIO_W-1:0]   topLevel,
  output logic [CHAN_W-1:0]   grantIdx,
  output logic                grantValid
);

  logic [CHAN_W-1:0] levelPtrQ [LEVELS];
  logic [CHAN_W-1:0] grantIdxQ;
  logic              grantValidQ;
  logic [CHAN_W-1:0] searchBase;
  logic [CHAN_W-1:0] pick;
  logic              pickFound;

  assign searchBase = strobe.prioSel ? levelPtrQ[topLevel] : grantIdxQ;

  // Rotating first-one search starting one past the base
  always_comb begin
    pick      = '0;
    pickFound = 1'b0;
    for (int i = 1; i <= NUM_CHAN; i++) begin
      if (!pickFound &&
          candMask[CHAN_W'((int'(searchBase) + i) % NUM_CHAN)]) begin
        pick      = CHAN_W'((int'(searchBase) + i) % NUM_CHAN);
        pickFound = 1'b1;
      end
    end
  end

  // One tie-break pointer per priority level
  for (genvar l = 0; l < LEVELS; l++) begin : gLevelPtr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        levelPtrQ[l] <= CHAN_W'(NUM_CHAN - 1);
      end else if (strobe.arbLoad && strobe.prioSel &&
                   (topLevel == PRIO_W'(l))) begin
        levelPtrQ[l] <= pick;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantIdxQ   <= '0;
      grantValidQ <= 1'b0;
    end else if (strobe.idleHold) begin
      grantValidQ <= 1'b0;
    end else if (strobe.arbLoad) begin
      grantIdxQ   <= pick;
      grantValidQ <= 1'b1;
    end
  end

  assign grantIdx   = grantIdxQ;
  assign grantValid = grantValidQ;

  AST_PICK_ON_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.arbLoad |-> pickFound); // R5

  AST_IDLE_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    strobe.idleHold |=> (!grantValidQ && $stable(grantIdxQ))); // R4

  AST_RR_MOVES_ON: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.arbLoad && !strobe.prioSel && ($countones(candMask) > 1))
      |=> (grantIdxQ != $past(grantIdxQ))); // R8

endmodule

// File: rtl/dmaReqArbiter.sv
module dmaReqArbiter
  import dmaArbPkg::*;
#(
  parameter int unsigned FIFO_CNT = DEF_FIFO_CNT,
  parameter int unsigned PRIO_W   = DEF_PRIO_W,
  localparam int unsigned NUM_CHAN = 2 * FIFO_CNT,
  localparam int unsigned CHAN_W   = $clog2(NUM_CHAN)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [FIFO_CNT-1:0]        wmReq,
  input  logic [FIFO_CNT-1:0]        hungryReq,
  input  logic [NUM_CHAN-1:0]        chanEn,
  input  logic [NUM_CHAN*PRIO_W-1:0] chanPrio,
  input  logic                       rrMode,
  output logic [CHAN_W-1:0]          grantIdx,
  output logic                       grantValid
);

  logic [NUM_CHAN-1:0] rawReq;
  logic [NUM_CHAN-1:0] effReq;
  logic [NUM_CHAN-1:0] candMask;
  logic [PRIO_W-1:0]   topLevel;
  arbStrobe_t          strobe;

  // Even channel: drain request, odd channel: fill request
  for (genvar f = 0; f < FIFO_CNT; f++) begin : gReqMap
    assign rawReq[2*f]   = wmReq[f];
    assign rawReq[2*f+1] = hungryReq[f];
  end

  assign effReq = rawReq & chanEn;

  dmaArbCtrl #(.NUM_CHAN(NUM_CHAN), .PRIO_W(PRIO_W)) u_ctrl (
    .effReq   (effReq),
    .chanPrio (chanPrio),
    .rrMode   (rrMode),
    .strobe   (strobe),
    .candMask (candMask),
    .topLevel (topLevel)
  );

  dmaArbDatapath #(.NUM_CHAN(NUM_CHAN), .PRIO_W(PRIO_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .candMask   (candMask),
    .topLevel   (topLevel),
    .grantIdx   (grantIdx),
    .grantValid (grantValid)
  );

  // Assertion support: one sampled cycle since reset release
  logic armedQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armedQ <= 1'b0;
    else       armedQ <= 1'b1;
  end

  function automatic logic noneHigher(input logic [NUM_CHAN-1:0] r,
                                      input logic [NUM_CHAN*PRIO_W-1:0] p,
                                      input logic [CHAN_W-1:0] g);
    logic ok;
    ok = 1'b1;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (r[c] && (p[c*PRIO_W +: PRIO_W] > p[int'(g)*PRIO_W +: PRIO_W])) ok = 1'b0;
    end
    return ok;
  endfunction

  AST_VALID_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> (grantValid == $past(|effReq))); // R5

  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && grantValid)
      |-> (|(($past(effReq) >> grantIdx) & NUM_CHAN'(1)))); // R3

  AST_TOP_LEVEL_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && grantValid && $past(!rrMode))
      |-> noneHigher($past(effReq), $past(chanPrio), grantIdx)); // R6

endmodule

// File: tb/dmaReqArbiter_bench.sv
`timescale 1ns/1ps
module dmaReqArbiter_bench;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  wmReq = '0;
  logic [7:0]  hungryReq = '0;
  logic [15:0] chanEn = '0;
  logic [63:0] chanPrio;
  logic        rrMode = 1'b0;
  logic [3:0]  grantIdx;
  logic        grantValid;

  logic [3:0]  prio [NCH];
  int          nChecks = 0;
  int          nFails = 0;
  int          expLast;
  int          expLvl [NCH];

  always #4 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) chanPrio[c*4 +: 4] = prio[c];
  end

  dmaReqArbiter u_dmaReqArbiter (
    .clk(clk), .rstN(rstN), .wmReq(wmReq), .hungryReq(hungryReq),
    .chanEn(chanEn), .chanPrio(chanPrio), .rrMode(rrMode),
    .grantIdx(grantIdx), .grantValid(grantValid)
  );

  task automatic check(input string tag, input int actV, input int actI,
                       input int expV, input int expI);
    nChecks++;
    if (actV != expV || (expV == 1 && actI != expI)) begin
      nFails++;
      $display("FAIL %s: valid=%0d idx=%0d expected valid=%0d idx=%0d",
               tag, actV, actI, expV, expI);
    end
  endtask

  // One slot: predict from the requirements, clock, check, update model
  task automatic slot(input string tag);
    logic [15:0] eff;
    int top, base, pickE, expV;
    for (int f = 0; f < 8; f++) begin      // R2 mapping
      eff[2*f]   = wmReq[f];
      eff[2*f+1] = hungryReq[f];
    end
    eff = eff & chanEn;                    // R3 masking
    top = 0;
    for (int c = 0; c < NCH; c++) if (eff[c] && prio[c] > top) top = prio[c];
    base  = rrMode ? expLast : expLvl[top];
    pickE = expLast;
    expV  = (eff != 0) ? 1 : 0;
    for (int i = NCH; i >= 1; i--) begin
      if (eff[(base + i) % NCH] && (rrMode || prio[(base + i) % NCH] == top))
        pickE = (base + i) % NCH;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(grantValid), int'(grantIdx), expV, pickE);
    if (expV == 1) begin
      expLast = pickE;                       // R10
      if (!rrMode) expLvl[top] = pickE;      // R9
    end
    if (expV == 0) check({tag, " R4 hold"}, 0, int'(grantIdx), 0, 0);
    if (expV == 0 && int'(grantIdx) != expLast) begin
      nChecks++; nFails++;
      $display("FAIL R4: idx=%0d expected held %0d", grantIdx, expLast);
    end
  endtask

  task automatic t_reset();
    check("R1 reset", int'(grantValid), int'(grantIdx), 0, 0);
    if (grantIdx != 4'd0) begin
      nFails++;
      $display("FAIL R1: idx=%0d expected 0", grantIdx);
    end
  endtask

  task automatic t_mapping();
    chanEn = 16'hFFFF; rrMode = 1'b0;
    wmReq = 8'h08; hungryReq = 8'h00;       // FIFO 3 drain -> channel 6
    slot("R2 drain ch6");
    wmReq = 8'h00; hungryReq = 8'h20;       // FIFO 5 fill -> channel 11
    slot("R2 fill ch11");
  endtask

  task automatic t_pulse();
    wmReq = 8'h00; hungryReq = 8'h04;       // single-cycle pulse on ch5
    slot("R5 pulse grant");
    hungryReq = 8'h00;
    slot("R5 pulse gone");
  endtask

  task automatic t_idle();
    wmReq = '0; hungryReq = '0;
    slot("R4 idle 1");
    slot("R4 idle 2");
  endtask

  task automatic t_enable();
    wmReq = 8'hFF; hungryReq = 8'hFF; chanEn = 16'h0000;
    slot("R3 all disabled");
    chanEn = 16'h0200;                      // only ch9
    for (int k = 0; k < 3; k++) slot("R3 only ch9");
    chanEn = 16'hFFFF;
  endtask

  task automatic t_prio();
    rrMode = 1'b0; wmReq = 8'hFF; hungryReq = 8'hFF;
    prio[3] = 4'd5; prio[10] = 4'd12;
    slot("R6 top level ch10");
    chanEn = 16'hFBFF;                      // drop ch10
    slot("R6 next level ch3");
    chanEn = 16'hFFFF;
    prio[3] = 4'd0; prio[10] = 4'd0;
  endtask

  task automatic t_tie();
    prio[1] = 4'd9; prio[5] = 4'd9; prio[12] = 4'd9; prio[14] = 4'd3;
    for (int k = 0; k < 4; k++) slot("R7 tie rotation");
  endtask

  task automatic t_rr();
    rrMode = 1'b1; wmReq = 8'h45; hungryReq = 8'h90;
    for (int k = 0; k < 5; k++) slot("R8 round robin");
    wmReq = 8'h00; hungryReq = 8'h40;       // only ch13
    slot("R10 rr single");
  endtask

  task automatic t_levelKeep();
    rrMode = 1'b0; wmReq = 8'hFF; hungryReq = 8'hFF;
    for (int k = 0; k < 3; k++) slot("R9 level pointer kept");
    prio[14] = 4'd15;
    slot("R9 other level");
    prio[14] = 4'd3;
    slot("R9 back to level 9");
    rrMode = 1'b1;
    slot("R10 rr after prio");
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      prio[c] = 4'd0;
      expLvl[c] = NCH - 1;
    end
    expLast = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mapping();
    t_pulse();
    t_idle();
    t_enable();
    t_prio();
    t_tie();
    t_rr();
    t_levelKeep();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule